// File: doc/BRIEF.md
# Queue Status and Interrupt Aggregator

This block gathers the condition flags that a queue engine reports for 64 hardware queues and turns them into host-readable status words and two interrupt lines. The queues fall into two groups of different richness. The 32 lower queues report empty, nearly-empty, nearly-full and full. Each also has a selectable interrupt source that can pick any of those four conditions or its inverse. The 32 upper queues report only nearly-empty and full, and their interrupt source is always nearly-empty.

Every queue owns a sticky interrupt flag, which is set when its chosen condition goes from false to true. The host clears a flag by writing a one to its bit. Per-queue enable masks gate the flags onto `irq_lo` (lower group) and `irq_hi` (upper group). For the lower group, the block also keeps sticky underflow and overflow indications, which are set by pulses from the queue engine. The host accesses everything through a flat 16-word register window: word writes, plus a side port that rewrites one lower queue's selector in isolation.

Top module: `qsa_aggregator`

## Requirements
- R1: Lower-group status appears at word addresses 0..3, one 4-bit field per queue. Queue q is in word q/8 at bits (q mod 8)*4. Within the field, bit 0 is empty, bit 1 nearly-empty, bit 2 nearly-full and bit 3 full. Each field shows the inputs that were sampled at the previous clock edge.
- R2: While reset is held, the following values apply. Words 0..3 read 0x33333333. Word 6 reads 0xFFFFFFFF. Words 4, 5, 7 and 8..15 read 0. `irq_lo`, `irq_hi` and `ctl_bit` are low.
- R3: Word 6 holds the upper-group nearly-empty bits and word 7 the upper-group full bits. Queue q (32..63) uses bit q-32. Both are sampled one edge after the inputs.
- R4: Words 4 and 5 hold sticky underflow/overflow bits for the lower queues. Queue q uses word 4+q/16, with underflow at bit 2*(q mod 16) and overflow one bit above it. A pulse on the input sets the bit. Writing a 1 to the bit clears it. A set and a clear in the same cycle leave the bit set.
- R5: Words 8..11 hold the lower-group selectors. Queue q uses word 8+q/8, bits (q mod 8)*4 to +2. The codes are 0 empty, 1 nearly-empty, 2 nearly-full, 3 full, 4 not-empty, 5 not-nearly-empty, 6 not-nearly-full and 7 not-full. The fourth bit of each slot reads 0, except in word 8.
- R6: Bit 3 of word 8 is a separate control bit, mirrored on `ctl_bit`, and only a word write to word 8 changes it. A selector side-port write (`sel_we`, `sel_qid`, `sel_code`) changes only the 3 selector bits of that one queue. If a word write hits the same queue in the same cycle, the side port takes precedence.
- R7: A lower queue's flag (word 14, bit q) is set at the edge after its selected condition, computed from the stored status and the stored selector, turns from 0 to 1. This includes a turn caused by a selector change. The flag then stays set until cleared.
- R8: An upper queue's flag (word 15, bit q-32) is set at the edge after its stored nearly-empty bit turns from 0 to 1.
- R9: Writing a 1 to a bit of word 14 or 15 clears that flag, and writing 0 leaves it unchanged. A new rise in the same cycle as the clear leaves the flag set.
- R10: Words 12 and 13 are read/write enable masks for the lower and upper queues. `irq_lo` is high exactly when some lower flag and its enable are both set, and `irq_hi` is the same for the upper group. There is no cycle of delay.
- R11: Word writes to addresses 0..3, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_empty | input | 32 | Empty condition, lower queues |
| lo_nempty | input | 32 | Nearly-empty condition, lower queues |
| lo_nfull | input | 32 | Nearly-full condition, lower queues |
| lo_full | input | 32 | Full condition, lower queues |
| hi_nempty | input | 32 | Nearly-empty condition, upper queues (bit q-32) |
| hi_full | input | 32 | Full condition, upper queues (bit q-32) |
| lo_uflow | input | 32 | Underflow event pulse, lower queues |
| lo_oflow | input | 32 | Overflow event pulse, lower queues |
| reg_we | input | 1 | Word write strobe |
| reg_addr | input | 4 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sel_we | input | 1 | Selector side-port write strobe |
| sel_qid | input | 5 | Lower queue whose selector is written |
| sel_code | input | 3 | New selector code |
| ctl_bit | output | 1 | Control bit kept in word 8 bit 3 |
| irq_lo | output | 1 | Interrupt for the lower group |
| irq_hi | output | 1 | Interrupt for the upper group |

## Verification
The bench goes after the edge detector. It toggles conditions back and forth, and it changes selectors while the status is steady. A design that is level-sensitive would keep raising flags after a clear, and one that ignored selector changes would miss edges caused by switching to an inverted code. It directs a clear write into the exact cycle in which a new rise arrives, which exposes a clear-over-set priority error. It sets the control bit and then rewrites queue 0's selector through the side port, which catches a full-nibble write that would wipe bit 3. It also writes to the read-only status words, which catches decoding that lets them be overwritten.

// File: rtl/qsa_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and helpers for the queue status aggregator.
// Assumes 32-bit register words and two groups of 32 queues.
package qsa_pkg;
    localparam int WORD_W      = 32;
    localparam int NUM_LO      = 32;
    localparam int NUM_HI      = 32;
    localparam int NIB_W       = 4;
    localparam int SEL_W       = 3;
    localparam int UO_BITS     = 2;
    localparam int ADDR_W      = 4;
    localparam int QID_W       = $clog2(NUM_LO);
    localparam int LO_PER_WORD = WORD_W / NIB_W;
    localparam int LO_WORDS    = NUM_LO / LO_PER_WORD;
    localparam int UO_WORDS    = (NUM_LO * UO_BITS) / WORD_W;

    // Selector codes; bit 2 inverts, bits 1:0 pick the status bit.
    typedef enum logic [SEL_W-1:0] {
        SRC_EMPTY, SRC_NEAR_EMPTY, SRC_NEAR_FULL, SRC_FULL,
        SRC_NOT_EMPTY, SRC_NOT_NEAR_EMPTY, SRC_NOT_NEAR_FULL, SRC_NOT_FULL
    } src_sel_e;

    // Word addresses of the host register window.
    typedef enum logic [ADDR_W-1:0] {
        RA_LOST0, RA_LOST1, RA_LOST2, RA_LOST3,
        RA_UO0, RA_UO1, RA_HI_NE, RA_HI_F,
        RA_SEL0, RA_SEL1, RA_SEL2, RA_SEL3,
        RA_EN_LO, RA_EN_HI, RA_FL_LO, RA_FL_HI
    } reg_addr_e;

    // Evaluate a selector code against one status nibble.
    function automatic logic src_hit(input logic [NIB_W-1:0] nib,
                                     input logic [SEL_W-1:0] code);
        return nib[code[1:0]] ^ code[2];
    endfunction
endpackage

// File: rtl/qsa_status_pack.sv
`timescale 1ns/1ps
// Samples the per-queue condition inputs into packed status words and
// keeps sticky underflow/overflow bits with write-1-to-clear.
// Assumes the flat nibble index q*4 equals word q/8, offset (q mod 8)*4.
module qsa_status_pack
    import qsa_pkg::*;
#(
    parameter int N_LO = NUM_LO,
    parameter int N_HI = NUM_HI,
    parameter int W    = WORD_W,
    localparam int LO_FLAT = N_LO * NIB_W,
    localparam int LO_WD   = LO_FLAT / W,
    localparam int UO_FLAT = N_LO * UO_BITS,
    localparam int UO_WD   = UO_FLAT / W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LO-1:0]           lo_empty,
    input  logic [N_LO-1:0]           lo_nempty,
    input  logic [N_LO-1:0]           lo_nfull,
    input  logic [N_LO-1:0]           lo_full,
    input  logic [N_HI-1:0]           hi_nempty,
    input  logic [N_HI-1:0]           hi_full,
    input  logic [N_LO-1:0]           lo_uflow,
    input  logic [N_LO-1:0]           lo_oflow,
    input  logic [UO_WD-1:0]          uo_clr_we,
    input  logic [W-1:0]              clr_data,
    output logic [LO_WD-1:0][W-1:0]   lo_stat,
    output logic [N_HI-1:0]           hi_ne_q,
    output logic [N_HI-1:0]           hi_f_q,
    output logic [UO_WD-1:0][W-1:0]   uo_q
);
    logic [LO_FLAT-1:0] lo_nxt;
    logic [UO_FLAT-1:0] uo_set;

    // Per-queue packing of conditions and event pulses.
    for (genvar q = 0; q < N_LO; q++) begin : g_pack
        assign lo_nxt[q*NIB_W +: NIB_W]   = {lo_full[q], lo_nfull[q], lo_nempty[q], lo_empty[q]};
        assign uo_set[q*UO_BITS +: UO_BITS] = {lo_oflow[q], lo_uflow[q]};
    end

    // Status capture: reset shows every queue empty and nearly-empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_stat <= {N_LO{4'b0011}};
            hi_ne_q <= '1;
            hi_f_q  <= '0;
        end else begin
            lo_stat <= lo_nxt;
            hi_ne_q <= hi_nempty;
            hi_f_q  <= hi_full;
        end
    end

    // Sticky underflow/overflow bits; a new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uo_q <= '0;
        end else begin
            for (int w = 0; w < UO_WD; w++) begin
                uo_q[w] <= (uo_q[w] & ~(uo_clr_we[w] ? clr_data : '0)) | uo_set[w*W +: W];
            end
        end
    end

    // R1: queue 0 field follows its inputs one edge later.
    a_r1_status_sampled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lo_stat[0][NIB_W-1:0] ==
                 $past({lo_full[0], lo_nfull[0], lo_nempty[0], lo_empty[0]}));

    // R3: upper nearly-empty word follows its input one edge later.
    a_r3_upper_sampled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hi_ne_q == $past(hi_nempty));

    // R4: a set underflow/overflow bit survives unless written with 1.
    a_r4_uo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(uo_q[0]) & ~($past(uo_clr_we[0]) ? $past(clr_data) : '0))
                  & ~uo_q[0]) == '0);

    // R4: an underflow pulse on queue 0 is seen next cycle.
    a_r4_uo_set: assert property (@(posedge clk) disable iff (!rst_n)
        lo_uflow[0] |=> uo_q[0][0]);
endmodule

// File: rtl/qsa_src_select.sv
`timescale 1ns/1ps
// Holds the lower-group interrupt source selectors plus the separate
// control bit, and evaluates each queue's selected condition.
// Assumes word writes and a per-queue side port; the side port wins.
module qsa_src_select
    import qsa_pkg::*;
#(
    parameter int N_LO = NUM_LO,
    parameter int W    = WORD_W,
    localparam int LO_FLAT = N_LO * NIB_W,
    localparam int LO_WD   = LO_FLAT / W,
    localparam int QPW     = W / NIB_W,
    localparam int QW      = $clog2(N_LO)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LO_WD-1:0]         word_we,
    input  logic [W-1:0]             wdata,
    input  logic                     fld_we,
    input  logic [QW-1:0]            fld_qid,
    input  logic [SEL_W-1:0]         fld_code,
    input  logic [LO_WD-1:0][W-1:0]  lo_stat,
    output logic [LO_WD-1:0][W-1:0]  sel_view,
    output logic                     ctl_bit,
    output logic [N_LO-1:0]          lo_cond
);
    logic [N_LO-1:0][SEL_W-1:0] sel_q;
    logic                       ctl_q;
    logic [LO_FLAT-1:0]         st_flat;
    logic [LO_FLAT-1:0]         view_flat;

    assign st_flat = lo_stat;

    // Selector storage: word write first, then side-port field write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            ctl_q <= 1'b0;
        end else begin
            for (int q = 0; q < N_LO; q++) begin
                if (word_we[q/QPW]) begin
                    sel_q[q] <= wdata[(q%QPW)*NIB_W +: SEL_W];
                end
                if (fld_we && (fld_qid == QW'(q))) begin
                    sel_q[q] <= fld_code;
                end
            end
            if (word_we[0]) begin
                ctl_q <= wdata[SEL_W];
            end
        end
    end

    // Readback slots and condition evaluation per queue.
    for (genvar q = 0; q < N_LO; q++) begin : g_slot
        if (q == 0) begin : g_ctl
            assign view_flat[q*NIB_W +: NIB_W] = {ctl_q, sel_q[q]};
        end else begin : g_plain
            assign view_flat[q*NIB_W +: NIB_W] = {1'b0, sel_q[q]};
        end
        assign lo_cond[q] = src_hit(st_flat[q*NIB_W +: NIB_W], sel_q[q]);
    end

    assign sel_view = view_flat;
    assign ctl_bit  = ctl_q;

    // R6: the side port never disturbs the control bit.
    a_r6_ctl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_we && !word_we[0]) |=> $stable(ctl_bit));

    // R6: with no word write at all, a side-port write hits its queue.
    a_r6_field_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_we && word_we == '0) |=>
            view_flat[$past(fld_qid)*NIB_W +: SEL_W] == $past(fld_code));
endmodule

// File: rtl/qsa_irq_flags.sv
`timescale 1ns/1ps
// Per-group interrupt enables, rising-edge detectors and sticky flags
// with write-1-to-clear; drives one interrupt line per group.
// Group 0 is the lower queues, group 1 the upper queues.
module qsa_irq_flags
    import qsa_pkg::*;
#(
    parameter int W = WORD_W,
    localparam int NG = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [W-1:0]           lo_cond,
    input  logic [W-1:0]           hi_cond,
    input  logic [NG-1:0]          en_we,
    input  logic [NG-1:0]          clr_we,
    input  logic [W-1:0]           wdata,
    output logic [NG-1:0][W-1:0]   en_q,
    output logic [NG-1:0][W-1:0]   flag_q,
    output logic                   irq_lo,
    output logic                   irq_hi
);
    logic [NG-1:0][W-1:0] cond;
    logic [NG-1:0][W-1:0] prev_q;
    logic [NG-1:0][W-1:0] rise;
    logic [NG-1:0]        irq_line;

    assign cond = {hi_cond, lo_cond};

    // Rising-edge detect per queue against last cycle's condition.
    always_comb begin
        for (int g = 0; g < NG; g++) begin
            rise[g] = cond[g] & ~prev_q[g];
        end
    end

    // Enables, previous condition and sticky flags; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            flag_q <= '0;
            prev_q <= '1;
        end else begin
            prev_q <= cond;
            for (int g = 0; g < NG; g++) begin
                if (en_we[g]) begin
                    en_q[g] <= wdata;
                end
                flag_q[g] <= (flag_q[g] & ~(clr_we[g] ? wdata : '0)) | rise[g];
            end
        end
    end

    // Interrupt lines gate flags through enables.
    for (genvar g = 0; g < NG; g++) begin : g_line
        assign irq_line[g] = |(flag_q[g] & en_q[g]);

        // R9: a flag not written with 1 stays set.
        a_r9_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (flag_q[g] & $past(flag_q[g] & ~(clr_we[g] ? wdata : '0)))
                     == $past(flag_q[g] & ~(clr_we[g] ? wdata : '0)));

        // R7 (group 0) / R8 (group 1): new flags only from a condition rise.
        a_r7_set_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (flag_q[g] & ~$past(flag_q[g])
                      & ~$past(cond[g] & ~prev_q[g])) == '0);
    end

    assign irq_lo = irq_line[0];
    assign irq_hi = irq_line[1];
endmodule

// File: rtl/qsa_aggregator.sv
`timescale 1ns/1ps
// Top of the queue status and interrupt aggregator: decodes the host
// word window, wires status packing, source selection and interrupt
// flags, and returns read data combinationally for reg_addr.
// Assumes the default sizes of qsa_pkg (two groups of 32 queues).
module qsa_aggregator
    import qsa_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LO-1:0]   lo_empty,
    input  logic [NUM_LO-1:0]   lo_nempty,
    input  logic [NUM_LO-1:0]   lo_nfull,
    input  logic [NUM_LO-1:0]   lo_full,
    input  logic [NUM_HI-1:0]   hi_nempty,
    input  logic [NUM_HI-1:0]   hi_full,
    input  logic [NUM_LO-1:0]   lo_uflow,
    input  logic [NUM_LO-1:0]   lo_oflow,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic                sel_we,
    input  logic [QID_W-1:0]    sel_qid,
    input  logic [SEL_W-1:0]    sel_code,
    output logic                ctl_bit,
    output logic                irq_lo,
    output logic                irq_hi
);
    logic [LO_WORDS-1:0][WORD_W-1:0] lo_stat;
    logic [LO_WORDS-1:0][WORD_W-1:0] sel_view;
    logic [UO_WORDS-1:0][WORD_W-1:0] uo_q;
    logic [NUM_HI-1:0]               hi_ne_q;
    logic [NUM_HI-1:0]               hi_f_q;
    logic [1:0][WORD_W-1:0]          en_q;
    logic [1:0][WORD_W-1:0]          flag_q;
    logic [NUM_LO-1:0]               lo_cond;
    logic [UO_WORDS-1:0]             uo_clr_we;
    logic [LO_WORDS-1:0]             sel_word_we;
    logic [1:0]                      en_we;
    logic [1:0]                      clr_we;

    // Write strobe decode per writable word.
    always_comb begin
        for (int w = 0; w < UO_WORDS; w++) begin
            uo_clr_we[w] = reg_we && (reg_addr == ADDR_W'(RA_UO0) + ADDR_W'(w));
        end
        for (int w = 0; w < LO_WORDS; w++) begin
            sel_word_we[w] = reg_we && (reg_addr == ADDR_W'(RA_SEL0) + ADDR_W'(w));
        end
        en_we  = {reg_we && (reg_addr == RA_EN_HI), reg_we && (reg_addr == RA_EN_LO)};
        clr_we = {reg_we && (reg_addr == RA_FL_HI), reg_we && (reg_addr == RA_FL_LO)};
    end

    qsa_status_pack u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_empty  (lo_empty),
        .lo_nempty (lo_nempty),
        .lo_nfull  (lo_nfull),
        .lo_full   (lo_full),
        .hi_nempty (hi_nempty),
        .hi_full   (hi_full),
        .lo_uflow  (lo_uflow),
        .lo_oflow  (lo_oflow),
        .uo_clr_we (uo_clr_we),
        .clr_data  (reg_wdata),
        .lo_stat   (lo_stat),
        .hi_ne_q   (hi_ne_q),
        .hi_f_q    (hi_f_q),
        .uo_q      (uo_q)
    );

    qsa_src_select u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_we  (sel_word_we),
        .wdata    (reg_wdata),
        .fld_we   (sel_we),
        .fld_qid  (sel_qid),
        .fld_code (sel_code),
        .lo_stat  (lo_stat),
        .sel_view (sel_view),
        .ctl_bit  (ctl_bit),
        .lo_cond  (lo_cond)
    );

    qsa_irq_flags u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_cond (lo_cond),
        .hi_cond (hi_ne_q),
        .en_we   (en_we),
        .clr_we  (clr_we),
        .wdata   (reg_wdata),
        .en_q    (en_q),
        .flag_q  (flag_q),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi)
    );

    // Read mux over the 16-word window.
    always_comb begin
        case (reg_addr)
            RA_LOST0: reg_rdata = lo_stat[0];
            RA_LOST1: reg_rdata = lo_stat[1];
            RA_LOST2: reg_rdata = lo_stat[2];
            RA_LOST3: reg_rdata = lo_stat[3];
            RA_UO0:   reg_rdata = uo_q[0];
            RA_UO1:   reg_rdata = uo_q[1];
            RA_HI_NE: reg_rdata = hi_ne_q;
            RA_HI_F:  reg_rdata = hi_f_q;
            RA_SEL0:  reg_rdata = sel_view[0];
            RA_SEL1:  reg_rdata = sel_view[1];
            RA_SEL2:  reg_rdata = sel_view[2];
            RA_SEL3:  reg_rdata = sel_view[3];
            RA_EN_LO: reg_rdata = en_q[0];
            RA_EN_HI: reg_rdata = en_q[1];
            RA_FL_LO: reg_rdata = flag_q[0];
            default:  reg_rdata = flag_q[1];
        endcase
    end

    // R10: with enables cleared, neither line can be high.
    a_r10_lines_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[0] == '0 && en_q[1] == '0) |-> (!irq_lo && !irq_hi));
endmodule

// File: tb/qsa_aggregator_tb_top.sv
`timescale 1ns/1ps
module qsa_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lo_empty, lo_nempty, lo_nfull, lo_full;
    logic [31:0] hi_nempty, hi_full, lo_uflow, lo_oflow;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        sel_we;
    logic [4:0]  sel_qid;
    logic [2:0]  sel_code;
    logic        ctl_bit, irq_lo, irq_hi;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    qsa_aggregator dut_i (.*);

    // Reference state, built from the requirements.
    logic [127:0] m_lo_st;
    logic [63:0]  m_uo;
    logic [31:0]  m_hi_ne, m_hi_f, m_en_lo, m_en_hi, m_fl_lo, m_fl_hi;
    logic [31:0]  m_prev_lo, m_prev_hi;
    logic [2:0]   m_sel [32];
    logic         m_ctl;

    function automatic logic m_cond(int q);
        logic [3:0] nib = m_lo_st[q*4 +: 4];
        logic [2:0] s   = m_sel[q];
        return nib[s[1:0]] ^ s[2];
    endfunction

    function automatic logic [31:0] m_read(logic [3:0] a);
        logic [31:0] v = '0;
        case (a)
            4'd0, 4'd1, 4'd2, 4'd3: v = m_lo_st[a*32 +: 32];
            4'd4, 4'd5: v = m_uo[(a-4)*32 +: 32];
            4'd6: v = m_hi_ne;
            4'd7: v = m_hi_f;
            4'd8, 4'd9, 4'd10, 4'd11: begin
                for (int k = 0; k < 8; k++) v[k*4 +: 4] = {1'b0, m_sel[(a-8)*8 + k]};
                if (a == 4'd8) v[3] = m_ctl;
            end
            4'd12: v = m_en_lo;
            4'd13: v = m_en_hi;
            4'd14: v = m_fl_lo;
            default: v = m_fl_hi;
        endcase
        return v;
    endfunction

    function automatic string addr_tag(logic [3:0] a);
        if (a < 4) return "R1";
        if (a < 6) return "R4";
        if (a < 8) return "R3";
        if (a < 12) return "R5";
        if (a < 14) return "R10";
        if (a == 14) return "R7";
        return "R8";
    endfunction

    task automatic model_reset();
        m_lo_st = {32{4'b0011}};
        m_uo = '0; m_hi_ne = '1; m_hi_f = '0;
        m_en_lo = '0; m_en_hi = '0; m_fl_lo = '0; m_fl_hi = '0;
        m_prev_lo = '1; m_prev_hi = '1; m_ctl = 1'b0;
        for (int q = 0; q < 32; q++) m_sel[q] = '0;
    endtask

    // Advance the reference by one clock edge using the driven inputs.
    task automatic model_update();
        logic [31:0] cl, ch, c0, c1;
        logic [63:0] set64, clr64;
        for (int q = 0; q < 32; q++) cl[q] = m_cond(q);
        ch = m_hi_ne;
        c0 = (reg_we && reg_addr == 4'd14) ? reg_wdata : '0;
        c1 = (reg_we && reg_addr == 4'd15) ? reg_wdata : '0;
        m_fl_lo = (m_fl_lo & ~c0) | (cl & ~m_prev_lo);
        m_fl_hi = (m_fl_hi & ~c1) | (ch & ~m_prev_hi);
        m_prev_lo = cl;
        m_prev_hi = ch;
        if (reg_we && reg_addr == 4'd12) m_en_lo = reg_wdata;
        if (reg_we && reg_addr == 4'd13) m_en_hi = reg_wdata;
        for (int q = 0; q < 32; q++) begin
            set64[2*q]   = lo_uflow[q];
            set64[2*q+1] = lo_oflow[q];
        end
        clr64 = '0;
        if (reg_we && reg_addr == 4'd4) clr64[31:0]  = reg_wdata;
        if (reg_we && reg_addr == 4'd5) clr64[63:32] = reg_wdata;
        m_uo = (m_uo & ~clr64) | set64;
        if (reg_we && reg_addr >= 4'd8 && reg_addr <= 4'd11) begin
            for (int k = 0; k < 8; k++) m_sel[(reg_addr-8)*8 + k] = reg_wdata[k*4 +: 3];
            if (reg_addr == 4'd8) m_ctl = reg_wdata[3];
        end
        if (sel_we) m_sel[sel_qid] = sel_code;
        for (int q = 0; q < 32; q++)
            m_lo_st[q*4 +: 4] = {lo_full[q], lo_nfull[q], lo_nempty[q], lo_empty[q]};
        m_hi_ne = hi_nempty;
        m_hi_f  = hi_full;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h (addr %0d, t=%0t)", tag, act, exp, reg_addr, $time);
        end
    endtask

    task automatic check_outputs(string tag);
        chk(tag == "" ? addr_tag(reg_addr) : tag, reg_rdata, m_read(reg_addr));
        chk("R10", {31'b0, irq_lo}, {31'b0, |(m_fl_lo & m_en_lo)});
        chk("R10", {31'b0, irq_hi}, {31'b0, |(m_fl_hi & m_en_hi)});
        chk("R6",  {31'b0, ctl_bit}, {31'b0, m_ctl});
    endtask

    // One cycle: check in the low phase, then step DUT and reference.
    task automatic tick(string tag);
        #1;
        check_outputs(tag);
        @(posedge clk);
        if (rst_n) model_update();
        @(negedge clk);
    endtask

    task automatic idle_ctl();
        reg_we = 1'b0; sel_we = 1'b0; lo_uflow = '0; lo_oflow = '0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, string tag);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick(tag);
        reg_we = 1'b0;
        tick(tag);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0051_7a6e));
        model_reset();
        lo_empty = '1; lo_nempty = '1; lo_nfull = '0; lo_full = '0;
        hi_nempty = '1; hi_full = '0;
        reg_addr = '0; reg_wdata = '0; sel_qid = '0; sel_code = '0;
        idle_ctl();
        repeat (3) @(negedge clk);

        // R2: reset values of every word and output.
        for (int a = 0; a < 16; a++) begin
            reg_addr = 4'(a);
            #1;
            chk("R2", reg_rdata, (a < 4) ? 32'h3333_3333 : (a == 6) ? 32'hFFFF_FFFF : 32'h0);
        end
        chk("R2", {29'b0, irq_lo, irq_hi, ctl_bit}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        tick("R1");

        // R11: writes to status words are ignored.
        wr(4'd0, 32'hCCCC_CCCC, "R11");
        wr(4'd2, 32'hFFFF_0000, "R11");
        wr(4'd6, 32'h0000_0000, "R11");
        wr(4'd7, 32'hFFFF_FFFF, "R11");

        // R6: set control bit, then side-port write to queue 0.
        wr(4'd8, 32'h0000_0008, "R6");
        sel_we = 1'b1; sel_qid = 5'd0; sel_code = 3'd5;
        reg_addr = 4'd8;
        tick("R6");
        sel_we = 1'b0;
        tick("R6");
        chk("R6", reg_rdata, 32'h0000_000D);
        // R5: word write then read back with slot bit 3 masked.
        wr(4'd9, 32'hFFFF_FFFF, "R5");
        chk("R5", reg_rdata, 32'h7777_7777);

        // R8/R9: upper nearly-empty rise coinciding with a clear write.
        wr(4'd13, 32'h0000_0001, "R10");
        hi_nempty[0] = 1'b0; reg_addr = 4'd15;
        tick("R8");
        hi_nempty[0] = 1'b1;
        tick("R8");
        reg_wdata = 32'h1; reg_we = 1'b1;
        tick("R9");
        reg_we = 1'b0;
        tick("R9");
        chk("R9", reg_rdata, 32'h1);
        chk("R9", {31'b0, irq_hi}, 32'h1);
        wr(4'd15, 32'h1, "R9");
        chk("R9", reg_rdata, 32'h0);

        // R7: inverted selector on a non-empty queue raises its flag.
        lo_empty[3] = 1'b0;
        reg_addr = 4'd14;
        tick("R7");
        tick("R7");
        sel_we = 1'b1; sel_qid = 5'd3; sel_code = 3'd4;
        tick("R7");
        sel_we = 1'b0;
        tick("R7");
        chk("R7", reg_rdata & 32'h8, 32'h8);

        // R4: underflow and overflow pulses, then clear.
        lo_uflow = 32'h0001_0000; lo_oflow = 32'h0000_0001; reg_addr = 4'd5;
        tick("R4");
        idle_ctl();
        tick("R4");
        chk("R4", reg_rdata, 32'h0000_0001);
        wr(4'd4, 32'h0000_0002, "R4");
        chk("R4", reg_rdata, 32'h0);

        // Random phase against the reference.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 4 == 0) lo_empty  ^= $urandom & $urandom & $urandom;
            if ($urandom % 4 == 0) lo_nempty ^= $urandom & $urandom & $urandom;
            if ($urandom % 4 == 0) lo_nfull  ^= $urandom & $urandom & $urandom;
            if ($urandom % 4 == 0) lo_full   ^= $urandom & $urandom & $urandom;
            if ($urandom % 4 == 0) hi_nempty ^= $urandom & $urandom & $urandom;
            if ($urandom % 4 == 0) hi_full   ^= $urandom & $urandom & $urandom;
            lo_uflow = ($urandom % 8 == 0) ? ($urandom & $urandom) : '0;
            lo_oflow = ($urandom % 8 == 0) ? ($urandom & $urandom) : '0;
            reg_addr  = 4'($urandom);
            reg_we    = ($urandom % 4 == 0);
            reg_wdata = $urandom;
            sel_we    = ($urandom % 8 == 0);
            sel_qid   = 5'($urandom);
            sel_code  = 3'($urandom);
            tick("");
        end
        idle_ctl();
        tick("");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule